// File: doc/BRIEF.md
# Dual-Channel PWM Slice

This block generates two pulse-width-modulated outputs from one shared 16-bit counter. A fractional clock divider, expressed in sixteenths, turns the system clock into count-enable ticks. On each tick the counter steps toward a programmable ceiling. Two compare levels taken from one packed word decide how long each output stays high in every period. Each output can be inverted on its own. A phase-correct mode makes the counter run up and then back down, which gives centre-aligned pulses at half the rate.

Software reaches the slice through a four-entry write port. The ceiling, the compare word and the divider are written into shadow copies. The slice copies them into its working set only at the end of a period, so no period mixes old and new settings. The control bits (phase-correct mode and the two inversions) take effect on the clock after they are written. An enable input freezes the slice while it is low and lets it continue from where it stopped.

Top module: `pwm_slice`

## Requirements
- R1: After reset the count is 0, both outputs are low, the working ceiling is 0xFFFF, both compare levels are 0, the divider is 0x010 (1.0) and all control bits are clear.
- R2: The divider is 12 bits in 8.4 fixed point (integer in bits [11:4], sixteenths in bits [3:0]). On each enabled clock an accumulator gains 16. A tick is issued when the sum reaches or passes the divider, and the remainder is kept. With 0x018 the counter advances 20 times in 30 clocks.
- R3: A divider below 0x010 acts as 0x010, so a tick occurs on every enabled clock.
- R4: In normal mode each tick raises the count by one until it equals the ceiling. The next tick returns it to 0, so a period lasts ceiling+1 ticks.
- R5: In phase-correct mode (control bit 0) the count rises to the ceiling, stays there for one more tick, falls to 0 and stays at 0 for one more tick. A period lasts 2×(ceiling+1) ticks.
- R6: The compare word carries level A in bits [15:0] and level B in bits [31:16]. An output is high while the count is below its level. A level of 0 keeps it low, and a level above the ceiling keeps it high.
- R7: Control bit 1 inverts output A and control bit 2 inverts output B. Both take effect on the clock after the write.
- R8: Writes to the ceiling, the compare word or the divider are held in shadow registers. They are copied to the working set only at a period boundary (a normal-mode wrap, or the tick that leaves the bottom in phase-correct mode), and only if a write has arrived since the last copy. A copy clears the divider accumulator. A write in the same clock as a copy waits for the next boundary.
- R9: While enable is low the count, the direction and the accumulator hold, and the outputs stay steady. When enable rises the slice continues from the held state.
- R10: A write is made by raising wr_en, with wr_sel choosing the target: 0 the ceiling (data [15:0]), 1 the compare word (data [31:0]), 2 the divider (data [11:0]), 3 the control bits (data [2:0]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run (1) or freeze (0) the slice |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 32 | Write data |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| count | output | 16 | Current counter value |

## Verification
The bench builds the slice with its default parameters: a 16-bit counter and an 8.4 divider. With these values it can let the reset ceiling of 0xFFFF run one full wrap, which is how its first shadowed writes get applied. It can also try a fractional divider of 1.5 and a divider below the legal minimum. A behavioural model follows the count and both outputs on every clock through normal and phase-correct periods, inversion, compare levels of zero and above the ceiling, freezes, and writes that wait for a boundary.

// File: rtl/pwm_slice_pkg.sv
// Package: shared types and constants for the PWM slice.
// Assumes: write-select codes and control bit positions below are the
// software-visible encoding.
package pwm_slice_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    localparam logic [1:0] SEL_TOP  = 2'd0;
    localparam logic [1:0] SEL_CMP  = 2'd1;
    localparam logic [1:0] SEL_DIV  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CTRL_W = 3;

    typedef struct packed {
        logic inv_b;
        logic inv_a;
        logic phase;
    } ctrl_t;

endpackage

// File: rtl/pwm_frac_div.sv
// Module: fractional tick generator.
// Adds one unit (2**FRAC_W) per enabled clock and emits a tick whenever the
// sum reaches the divider, keeping the remainder. Divider values below one
// unit act as one unit. Assumes div_i only changes together with clr_i.
module pwm_frac_div #(
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int ACC_W = DIV_W + 1;
    localparam logic [DIV_W-1:0] UNIT = DIV_W'(1 << FRAC_W);

    logic [DIV_W-1:0] acc_q;
    logic [DIV_W-1:0] div_eff;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] rem;

    // Clamp the divider to its legal minimum and form the next sum.
    always_comb begin
        div_eff = (div_i < UNIT) ? UNIT : div_i;
        sum     = {1'b0, acc_q} + {1'b0, UNIT};
        rem     = sum - {1'b0, div_eff};
        tick_o  = en_i && (sum >= {1'b0, div_eff});
    end

    // Phase accumulator: keep the remainder, clear on a working-set copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr_i) begin
            acc_q <= '0;
        end else if (en_i) begin
            acc_q <= tick_o ? rem[DIV_W-1:0] : sum[DIV_W-1:0];
        end
    end

    AST_ACC_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < div_eff); // R2
    AST_UNITY_EVERY_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && div_i <= UNIT) |-> tick_o); // R3

endmodule

// File: rtl/pwm_counter.sv
// Module: period counter, normal (sawtooth) or phase-correct (triangle).
// Steps only on tick_i. Flags the period boundary in the tick that ends a
// period. Assumes top_i changes only at a boundary.
module pwm_counter
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             phase_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             boundary_o
);
    logic [CNT_W-1:0] cnt_q;
    cnt_dir_e         dir_q;

    // A period ends on a normal wrap or when leaving the bottom going down.
    always_comb begin
        if (!phase_i) begin
            boundary_o = tick_i && (cnt_q >= top_i);
        end else begin
            boundary_o = tick_i && (dir_q == DIR_DOWN) && (cnt_q == '0);
        end
    end

    // Count step per tick; ends are held one extra tick in triangle mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else if (tick_i) begin
            if (!phase_i) begin
                dir_q <= DIR_UP;
                cnt_q <= (cnt_q >= top_i) ? '0 : cnt_q + 1'b1;
            end else if (dir_q == DIR_UP) begin
                if (cnt_q >= top_i) dir_q <= DIR_DOWN;
                else                cnt_q <= cnt_q + 1'b1;
            end else begin
                if (cnt_q == '0) dir_q <= DIR_UP;
                else             cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_WITHIN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= top_i); // R4
    AST_BOTTOM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i && tick_i && dir_q == DIR_DOWN && cnt_q == '0) |=> cnt_q == '0); // R5

endmodule

// File: rtl/pwm_slice_regs.sv
// Module: write decode, shadow registers and working set.
// Shadows load on a write; the working set takes the shadows at a period
// boundary only when a write is pending. Control bits apply immediately.
module pwm_slice_regs
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 12,
    parameter int FRAC_W = 4,
    parameter logic [CNT_W-1:0] RST_TOP = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [2*CNT_W-1:0] wr_data_i,
    input  logic               boundary_i,
    output logic               load_o,
    output logic [CNT_W-1:0]   top_o,
    output logic [2*CNT_W-1:0] cmp_o,
    output logic [DIV_W-1:0]   div_o,
    output ctrl_t              ctrl_o
);
    localparam logic [DIV_W-1:0] UNIT = DIV_W'(1 << FRAC_W);

    logic [CNT_W-1:0]   top_sh, top_q;
    logic [2*CNT_W-1:0] cmp_sh, cmp_q;
    logic [DIV_W-1:0]   div_sh, div_q;
    logic               pend_q;
    ctrl_t              ctrl_q;
    logic               shadow_wr;

    assign shadow_wr = wr_en_i && (wr_sel_i != SEL_CTRL);
    assign load_o    = boundary_i && pend_q;

    // Shadow capture and control register from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_sh <= RST_TOP;
            cmp_sh <= '0;
            div_sh <= UNIT;
            ctrl_q <= '0;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                SEL_TOP: top_sh <= wr_data_i[CNT_W-1:0];
                SEL_CMP: cmp_sh <= wr_data_i;
                SEL_DIV: div_sh <= wr_data_i[DIV_W-1:0];
                default: ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
            endcase
        end
    end

    // Working-set copy at a boundary, and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q  <= RST_TOP;
            cmp_q  <= '0;
            div_q  <= UNIT;
            pend_q <= 1'b0;
        end else begin
            if (load_o) begin
                top_q <= top_sh;
                cmp_q <= cmp_sh;
                div_q <= div_sh;
            end
            if (shadow_wr)   pend_q <= 1'b1;
            else if (load_o) pend_q <= 1'b0;
        end
    end

    assign top_o  = top_q;
    assign cmp_o  = cmp_q;
    assign div_o  = div_q;
    assign ctrl_o = ctrl_q;

    AST_SET_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> ($stable(top_q) && $stable(cmp_q) && $stable(div_q))); // R8
    AST_NO_COPY_UNREQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> ($stable(top_q) && $stable(cmp_q) && $stable(div_q))); // R8

endmodule

// File: rtl/pwm_chan_out.sv
// Module: one compare output. High while count < level, optionally inverted.
// Assumes the count never exceeds the working ceiling.
module pwm_chan_out #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] level_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             inv_i,
    output logic             pin_o
);
    // Compare and polarity select.
    always_comb begin
        pin_o = (cnt_i < level_i) ^ inv_i;
    end

    AST_LEVEL_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i == '0) |-> (pin_o == inv_i)); // R6
    AST_LEVEL_ABOVE_TOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i > top_i) |-> (pin_o == !inv_i)); // R6

endmodule

// File: rtl/pwm_slice.sv
// Module: dual-channel PWM slice top.
// Ties the register block, fractional divider, counter and two compare
// outputs together. Assumes one clock domain and synchronous active-low reset.
module pwm_slice
    import pwm_slice_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int DIV_INT_W = 8,
    parameter int DIV_FRAC_W = 4,
    parameter logic [CNT_W-1:0] RST_TOP = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [2*CNT_W-1:0] wr_data,
    output logic               out_a,
    output logic               out_b,
    output logic [CNT_W-1:0]   count
);
    localparam int DIV_W = DIV_INT_W + DIV_FRAC_W;
    localparam int N_CH  = 2;

    logic               tick, boundary, load;
    logic [CNT_W-1:0]   top_act;
    logic [2*CNT_W-1:0] cmp_act;
    logic [DIV_W-1:0]   div_act;
    ctrl_t              ctrl;
    logic [N_CH-1:0]    pins;
    logic [N_CH-1:0]    inv_vec;

    pwm_slice_regs #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .FRAC_W(DIV_FRAC_W), .RST_TOP(RST_TOP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .boundary_i(boundary), .load_o(load),
        .top_o(top_act), .cmp_o(cmp_act), .div_o(div_act), .ctrl_o(ctrl)
    );

    pwm_frac_div #(.DIV_W(DIV_W), .FRAC_W(DIV_FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en_i(enable), .clr_i(load),
        .div_i(div_act), .tick_o(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .phase_i(ctrl.phase),
        .top_i(top_act), .cnt_o(count), .boundary_o(boundary)
    );

    assign inv_vec = {ctrl.inv_b, ctrl.inv_a};

    // One compare output per channel; level ch sits in slice ch of the word.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        pwm_chan_out #(.CNT_W(CNT_W)) u_out (
            .clk(clk), .rst_n(rst_n), .cnt_i(count),
            .level_i(cmp_act[ch*CNT_W +: CNT_W]), .top_i(top_act),
            .inv_i(inv_vec[ch]), .pin_o(pins[ch])
        );
    end

    assign out_a = pins[0];
    assign out_b = pins[1];

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(count) && $stable(out_a) && $stable(out_b))); // R9
    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick); // R9

endmodule

// File: tb/pwm_slice_test.sv
`timescale 1ns/1ps
module pwm_slice_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        out_a, out_b;
    logic [15:0] count;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pwm_slice uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .out_a(out_a), .out_b(out_b),
        .count(count)
    );

    // Behavioural reference model, advanced at each rising edge.
    int          m_acc, m_cnt, m_top, m_div, s_top, s_div;
    logic [31:0] m_cmp, s_cmp;
    logic [2:0]  m_ctrl;
    bit          m_dn, m_pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_cnt = 0; m_dn = 0; m_pend = 0;
            m_top = 16'hFFFF; s_top = 16'hFFFF;
            m_div = 16; s_div = 16;
            m_cmp = '0; s_cmp = '0; m_ctrl = '0;
        end else begin
            int  deff, sum, nacc;
            bit  tk, bnd;
            tk = 0; bnd = 0; nacc = m_acc;
            deff = (m_div < 16) ? 16 : m_div;
            if (enable) begin
                sum = m_acc + 16;
                if (sum >= deff) begin tk = 1; nacc = sum - deff; end
                else nacc = sum;
            end
            if (tk) begin
                if (!m_ctrl[0]) begin
                    m_dn = 0;
                    if (m_cnt >= m_top) begin m_cnt = 0; bnd = 1; end
                    else m_cnt++;
                end else if (!m_dn) begin
                    if (m_cnt >= m_top) m_dn = 1; else m_cnt++;
                end else begin
                    if (m_cnt == 0) begin m_dn = 0; bnd = 1; end
                    else m_cnt--;
                end
            end
            if (bnd && m_pend) begin
                m_top = s_top; m_cmp = s_cmp; m_div = s_div;
                m_pend = 0; nacc = 0;
            end
            m_acc = nacc;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin s_top = int'(wr_data[15:0]); m_pend = 1; end
                    2'd1: begin s_cmp = wr_data; m_pend = 1; end
                    2'd2: begin s_div = int'(wr_data[11:0]); m_pend = 1; end
                    default: m_ctrl = wr_data[2:0];
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit ea, eb;
            ea = (m_cnt < int'(m_cmp[15:0])) ^ m_ctrl[1];
            eb = (m_cnt < int'(m_cmp[31:16])) ^ m_ctrl[2];
            chk(int'(count) == m_cnt, "R4/R5 count vs model", int'(count), m_cnt);
            chk(out_a == ea, "R6/R7 out_a vs model", int'(out_a), int'(ea));
            chk(out_b == eb, "R6/R7 out_b vs model", int'(out_b), int'(eb));
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_wrap();
        while (count == 16'd0) @(negedge clk);
        while (count != 16'd0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] held;
        logic        ha, hb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(count == 16'd0, "R1 reset count", int'(count), 0);
        chk(out_a == 1'b0, "R1 reset out_a", int'(out_a), 0);
        chk(out_b == 1'b0, "R1 reset out_b", int'(out_b), 0);

        // R10 ceiling write, shadowed until the reset ceiling wraps (R8).
        wr(2'd0, 32'd9);
        enable = 1'b1;
        repeat (20) @(negedge clk);
        chk(count > 16'd9, "R8 old ceiling still in force", int'(count), 20);
        wait_wrap();
        repeat (5) @(negedge clk);
        chk(count == 16'd5, "R4 count mid period", int'(count), 5);
        repeat (5) @(negedge clk);
        chk(count == 16'd0, "R4 wrap after ceiling+1 ticks", int'(count), 0);

        wr(2'd1, {16'd7, 16'd3});
        repeat (25) @(negedge clk);

        // R2 fractional divider 1.5 with a larger ceiling.
        enable = 1'b0;
        wr(2'd0, 32'd999);
        wr(2'd2, 32'h018);
        enable = 1'b1;
        wait_wrap();
        repeat (30) @(negedge clk);
        chk(count == 16'd20, "R2 ticks in 30 clocks at 1.5", int'(count), 20);

        // R3 divider below legal minimum.
        enable = 1'b0;
        wr(2'd2, 32'h005);
        wr(2'd0, 32'd19);
        enable = 1'b1;
        wait_wrap();
        repeat (7) @(negedge clk);
        chk(count == 16'd7, "R3 sub-minimum divider ticks every clock", int'(count), 7);

        // R6 level zero and level above ceiling.
        enable = 1'b0;
        wr(2'd1, {16'hFFFF, 16'h0000});
        enable = 1'b1;
        wait_wrap();
        repeat (4) @(negedge clk);
        chk(out_a == 1'b0, "R6 level zero keeps A low", int'(out_a), 0);
        chk(out_b == 1'b1, "R6 level above ceiling keeps B high", int'(out_b), 1);

        // R7 / R10 inversion through the control write.
        wr(2'd3, 32'h6);
        chk(out_a == 1'b1, "R7 R10 inverted A", int'(out_a), 1);
        chk(out_b == 1'b0, "R7 R10 inverted B", int'(out_b), 0);
        repeat (12) @(negedge clk);

        // R5 phase-correct turnarounds.
        wr(2'd1, {16'd12, 16'd5});
        wr(2'd3, 32'h1);
        while (count != 16'd19) @(negedge clk);
        @(negedge clk);
        chk(count == 16'd19, "R5 ceiling held one extra tick", int'(count), 19);
        @(negedge clk);
        chk(count == 16'd18, "R5 count falls after ceiling", int'(count), 18);
        while (count != 16'd0) @(negedge clk);
        @(negedge clk);
        chk(count == 16'd0, "R5 bottom held one extra tick", int'(count), 0);
        @(negedge clk);
        chk(count == 16'd1, "R5 count rises after bottom", int'(count), 1);

        // R9 freeze and resume.
        repeat (6) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        held = count; ha = out_a; hb = out_b;
        repeat (10) @(negedge clk);
        chk(count == held, "R9 count held while disabled", int'(count), int'(held));
        chk(out_a == ha && out_b == hb, "R9 outputs held while disabled",
            int'({out_a, out_b}), int'({ha, hb}));
        enable = 1'b1;

        // R8 ceiling change in phase-correct mode waits for the bottom.
        wr(2'd0, 32'd5);
        repeat (100) @(negedge clk);
        wr(2'd3, 32'h0);
        repeat (40) @(negedge clk);
        finish_run();
    end

endmodule